// File: doc/BRIEF.md
# Parity-Group Concurrent Error Detector

This block computes a fixed 8-bit to 8-bit combinational map and checks every result for a single error while it runs. The eight outputs are split into three parity groups. A separate predictor derives each group's expected parity straight from the registered inputs. A checker folds each group's actual outputs together with that group's predicted bit, and any nonzero fold marks that group as failed. The failure indication is sticky until software-free logic upstream pulses a synchronous clear.

Inside a group, each output is built from its own gates. Logic terms are shared only between outputs that sit in different groups. Because of this, one faulty internal line can corrupt at most one bit per group, and every group it reaches flags it. For testing, an injection input selects one output line or one predicted parity line and inverts it for the vector captured with it. Tests can then show that the block is fault-secure and self-testing.

Top module: `parity_group_ced`

## Requirements
- R1: While `rst_ni` is low and after it is released, `data_o`, `err_o` and `grp_err_o` are all zero until the first result reaches them.
- R2: The input presented at one rising edge produces `data_o` two rising edges later. With x the input and t[j] = x[j] & x[(j+1) mod 8], output bit k is x[(k+4) mod 8] ^ t[k] ^ t[(k+7) mod 8].
- R3: Without injection, no input vector ever sets any bit of `grp_err_o`.
- R4: Output bit k belongs to parity group k mod 3. The group table is a parameter with a 2-bit field per output, field k at bits [2k+1:2k], default 16'h4924. A term shared by outputs k and k+1 always spans two groups.
- R5: `inj_sel_i` values 0 to 7 invert output bit `inj_sel_i`, and values 8 to 10 invert the predicted parity of group `inj_sel_i`-8. Values 11 to 15 have no effect. The selection is captured with the data when `inj_en_i` is high and affects only that vector's result.
- R6: Any single injected line sets the `grp_err_o` bit of the group that line belongs to, on the same edge its result reaches `data_o`. `err_o` is high whenever any `grp_err_o` bit is set.
- R7: Fault-secure: whenever `data_o` differs from the R2 value, `err_o` is high in that same cycle.
- R8: `grp_err_o` bits stay set until `clr_i` is high at a rising edge. A group mismatch arriving on that same edge wins over the clear.
- R9: Self-testing: for every injectable line, at least one input vector makes the checker flag it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Function input |
| inj_en_i | input | 1 | Enable fault injection for the vector captured at this edge |
| inj_sel_i | input | 4 | Line to invert (outputs 0-7, predicted parities 8-10) |
| clr_i | input | 1 | Synchronous clear of sticky group errors |
| data_o | output | 8 | Registered function result |
| err_o | output | 1 | OR of sticky group errors |
| grp_err_o | output | 3 | Sticky per-group error status |

## Verification
The bench sweeps all 256 inputs without injection. A predictor that disagreed with the function on even one vector would raise a false alarm. It then inverts every selectable line on every vector. A wrong group table or a broken group fold would then show the wrong status bit, or none at all, and a decode that picked the wrong line would corrupt the wrong output bit. Selections 11 to 15 must leave both data and status clean, so an over-eager decoder would show up. The sticky tests clear status, accumulate two groups, and pulse the clear on the same edge as a fresh mismatch. A design that let the clear win, or that dropped bits without a clear, would lose a recorded error.

// File: rtl/pgced_pkg.sv
package pgced_pkg;
  localparam int DW_DEF = 8;
  localparam int NG_DEF = 3;
  // output k -> group k mod 3, 2-bit field per output
  localparam logic [15:0] GMAP_DEF = 16'h4924;
endpackage

// File: rtl/pgced_func.sv
module pgced_func #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] y_o
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] t;

  // t[j] feeds only y[j] and y[j+1]; these lie in different groups
  for (genvar j = 0; j < DW; j++) begin : g_term
    assign t[j] = x_i[j] & x_i[(j + 1) % DW];
  end

  for (genvar k = 0; k < DW; k++) begin : g_out
    assign y_o[k] = x_i[(k + HALF) % DW] ^ t[k] ^ t[(k + DW - 1) % DW];
  end
endmodule

// File: rtl/pgced_pred.sv
module pgced_pred #(
  parameter int             DW   = 8,
  parameter int             NG   = 3,
  parameter int             GW   = 2,
  parameter logic [DW*GW-1:0] GMAP = 16'h4924
) (
  input  logic [DW-1:0] x_i,
  output logic [NG-1:0] p_o
);
  localparam int HALF = DW / 2;

  // parity derived from inputs, no reuse of the function's gates
  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_comb begin
      p_o[g] = 1'b0;
      for (int k = 0; k < DW; k++) begin
        if (int'(GMAP[GW*k +: GW]) == g) begin
          p_o[g] = p_o[g] ^ x_i[(k + HALF) % DW]
                          ^ (x_i[k] & x_i[(k + 1) % DW])
                          ^ (x_i[(k + DW - 1) % DW] & x_i[k]);
        end
      end
    end
  end
endmodule

// File: rtl/pgced_chk.sv
module pgced_chk #(
  parameter int             DW   = 8,
  parameter int             NG   = 3,
  parameter int             GW   = 2,
  parameter logic [DW*GW-1:0] GMAP = 16'h4924
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] y_i,
  input  logic [NG-1:0] p_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic [NG-1:0] sticky_o,
  output logic [NG-1:0] mis_o
);
  logic [NG-1:0] sticky_q;

  for (genvar g = 0; g < NG; g++) begin : g_fold
    logic [DW-1:0] mask;
    for (genvar k = 0; k < DW; k++) begin : g_m
      assign mask[k] = (int'(GMAP[GW*k +: GW]) == g);
    end
    assign mis_o[g] = ^(y_i & mask) ^ p_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      sticky_q <= '0;
    end else begin
      data_o   <= y_i;
      sticky_q <= (clr_i ? '0 : sticky_q) | mis_o;
    end
  end

  assign sticky_o = sticky_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mis_o == '0) |=> (sticky_q == '0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mis_o != '0) |=> (sticky_q == $past(mis_o)));
endmodule

// File: rtl/parity_group_ced.sv
module parity_group_ced #(
  parameter int               DW    = pgced_pkg::DW_DEF,
  parameter int               NG    = pgced_pkg::NG_DEF,
  parameter int               GW    = 2,
  parameter logic [DW*GW-1:0] GMAP  = pgced_pkg::GMAP_DEF,
  localparam int              SEL_W = $clog2(DW + NG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    data_i,
  input  logic             inj_en_i,
  input  logic [SEL_W-1:0] inj_sel_i,
  input  logic             clr_i,
  output logic [DW-1:0]    data_o,
  output logic             err_o,
  output logic [NG-1:0]    grp_err_o
);
  logic [DW-1:0]    x_q;
  logic             inj_q;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    y_raw, y_f, flip_y;
  logic [NG-1:0]    p_raw, p_f, flip_p;
  logic [NG-1:0]    sticky, mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      inj_q <= 1'b0;
      sel_q <= '0;
    end else begin
      x_q   <= data_i;
      inj_q <= inj_en_i;
      sel_q <= inj_sel_i;
    end
  end

  pgced_func #(.DW(DW)) u_func (.x_i(x_q), .y_o(y_raw));

  pgced_pred #(.DW(DW), .NG(NG), .GW(GW), .GMAP(GMAP)) u_pred (
    .x_i(x_q), .p_o(p_raw)
  );

  // injection decode: one line per select value
  for (genvar k = 0; k < DW; k++) begin : g_fy
    assign flip_y[k] = inj_q && (sel_q == SEL_W'(k));
  end
  for (genvar g = 0; g < NG; g++) begin : g_fp
    assign flip_p[g] = inj_q && (sel_q == SEL_W'(DW + g));
  end

  assign y_f = y_raw ^ flip_y;
  assign p_f = p_raw ^ flip_p;

  pgced_chk #(.DW(DW), .NG(NG), .GW(GW), .GMAP(GMAP)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .y_i     (y_f),
    .p_i     (p_f),
    .clr_i   (clr_i),
    .data_o  (data_o),
    .sticky_o(sticky),
    .mis_o   (mis)
  );

  assign grp_err_o = sticky;
  assign err_o     = |sticky;

  p_single_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flip_y, flip_p}));

  p_no_inj_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_q |-> (mis == '0));

  p_detect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_q && sel_q < SEL_W'(DW + NG)) |=> err_o);

  p_fault_secure_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_f != y_raw) |=> (err_o && data_o != $past(y_raw)));
endmodule

// File: tb/parity_group_ced_tb.sv
module parity_group_ced_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       inj_en_i = 1'b0;
  logic [3:0] inj_sel_i = '0;
  logic       clr_i = 1'b0;
  logic [7:0] data_o;
  logic       err_o;
  logic [2:0] grp_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  parity_group_ced dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .inj_en_i(inj_en_i),
    .inj_sel_i(inj_sel_i), .clr_i(clr_i), .data_o(data_o), .err_o(err_o),
    .grp_err_o(grp_err_o)
  );

  function automatic logic [7:0] model(input logic [7:0] v);
    logic [7:0] t, y;
    for (int j = 0; j < 8; j++) t[j] = v[j] & v[(j + 1) % 8];
    for (int k = 0; k < 8; k++) y[k] = v[(k + 4) % 8] ^ t[k] ^ t[(k + 7) % 8];
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present at negedge; inject on first edge only; result at 2nd edge
  task automatic run_vec(input logic [7:0] v, input logic en,
                         input logic [3:0] sel, input logic clr);
    data_i = v; inj_en_i = en; inj_sel_i = sel; clr_i = clr;
    @(posedge clk_i); @(negedge clk_i);
    inj_en_i = 1'b0; clr_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_d;
    logic [2:0] exp_g;
    int hits;

    repeat (3) @(negedge clk_i);
    chk(data_o == 0 && err_o == 0 && grp_err_o == 0, "R1 in reset",
        {data_o, err_o, grp_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(data_o == 0 && err_o == 0 && grp_err_o == 0, "R1 after release",
        {data_o, err_o, grp_err_o}, 0);

    // clean sweep
    for (int v = 0; v < 256; v++) begin
      run_vec(8'(v), 1'b0, 4'd0, 1'b0);
      chk(data_o == model(8'(v)), "R2 function", data_o, model(8'(v)));
      chk(grp_err_o == 3'b000, "R3 no false alarm", grp_err_o, 0);
    end

    // every select on every vector
    for (int s = 0; s < 16; s++) begin
      hits = 0;
      for (int v = 0; v < 256; v++) begin
        run_vec(8'(v), 1'b1, 4'(s), 1'b1);
        exp_d = model(8'(v));
        exp_g = 3'b000;
        if (s < 8) begin
          exp_d[s] = ~exp_d[s];
          exp_g = 3'(1 << (s % 3)); // R4 group k mod 3
        end else if (s < 11) begin
          exp_g = 3'(1 << (s - 8));
        end
        chk(data_o == exp_d, "R5 injected data", data_o, exp_d);
        chk(grp_err_o == exp_g, "R6 group status", grp_err_o, exp_g);
        chk(err_o == (exp_g != 0), "R6 err_o", err_o, exp_g != 0);
        if (data_o != model(8'(v)))
          chk(err_o == 1'b1, "R7 fault-secure", err_o, 1);
        if (err_o) hits++;
      end
      if (s < 11) chk(hits > 0, "R9 self-testing", hits, 1);
      else chk(hits == 0, "R5 unused select", hits, 0);
    end

    // sticky behaviour
    run_vec(8'h5A, 1'b1, 4'd2, 1'b1);
    chk(grp_err_o == 3'b100, "R8 set", grp_err_o, 3'b100);
    for (int i = 0; i < 3; i++) begin
      run_vec(8'h33, 1'b0, 4'd0, 1'b0);
      chk(grp_err_o == 3'b100 && err_o, "R8 hold", grp_err_o, 3'b100);
      chk(data_o == model(8'h33), "R2 after fault", data_o, model(8'h33));
    end
    run_vec(8'hC4, 1'b1, 4'd9, 1'b0);
    chk(grp_err_o == 3'b110, "R8 accumulate", grp_err_o, 3'b110);
    run_vec(8'h00, 1'b0, 4'd0, 1'b1);
    chk(grp_err_o == 3'b000 && !err_o, "R8 clear", grp_err_o, 0);

    // clear on same edge as a fresh mismatch
    data_i = 8'h81; inj_en_i = 1'b1; inj_sel_i = 4'd0; clr_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    inj_en_i = 1'b0; clr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    clr_i = 1'b0;
    chk(grp_err_o == 3'b001, "R8 set wins over clear", grp_err_o, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule